// File: doc/BRIEF.md
# Serial EEPROM Write-Permission Guard

This block keeps the protection state of a 4 KB serial EEPROM and decides, cycle by cycle, whether an array write or a status-register write may start. A command decoder feeds it strobes that raise or drop the write-enable latch and the user flag. The decoder also sends array write requests, each with an address, and status write requests, each with a data byte. The guard answers each request at once with accept or deny. It then tracks the accepted nonvolatile write for a fixed number of cycles. When that write ends, it commits the new protection settings and drops the write-enable latch.

The protection state has five parts: the write-enable latch, the volatile flag, two block-lock bits that select a locked top portion of the array, and a lock-enable bit. The lock-enable bit works together with the external write-protect pin to freeze the status register. Query ports let the decoder ask about any address without starting a write. Reads are never restricted. The lock-enable and block-lock bits stand for nonvolatile cells: a power-on reset clears them and a warm reset leaves them untouched.

Top module: `nvm_write_guard`

## Requirements
- R1: `status_q` reads as {lock-enable (bit 7), flag (bit 6), 1 (bit 5), 1 (bit 4), block-lock high (bit 3), block-lock low (bit 2), write-enable latch (bit 1), write busy (bit 0)}.
- R2: With a 12-bit address, block-lock value 00 locks nothing, 01 locks 0xC00..0xFFF, 10 locks 0x800..0xFFF and 11 locks every address. `q_locked` reports this for `q_addr`. An array write to a locked address is denied.
- R3: While the write-enable latch is 0, every array write request and every status write request is denied, and both `q_arr_ok` and `q_stat_ok` are 0.
- R4: With the latch at 1, lock-enable at 1 and `wp_pin` low, status writes are denied while array writes to unlocked addresses are still accepted.
- R5: With the latch at 1 and either lock-enable at 0 or `wp_pin` high, status writes are accepted.
- R6: An accepted write keeps `busy` high for exactly WR_CYCLES cycles, starting the cycle after acceptance. On the cycle after the last busy cycle, `wr_done` pulses, the write-enable latch reads 0 and a status write's new settings become visible.
- R7: Taking `wp_pin` low while an accepted status write is busy does not stop that write from committing. The lock then denies the next status write.
- R8: `flag_set` sets the flag and `flag_clr` clears it. `wel_set` sets the latch and `wel_clr` clears it. When set and clear arrive in the same cycle, clear wins.
- R9: A `warm_rst` pulse clears the latch, the flag and any write in progress, with no commit and no `wr_done`, and keeps lock-enable and block-lock. `por_n` low clears everything.
- R10: A status write stores only data bits 7, 3 and 2 (lock-enable, block-lock high, block-lock low). All other data bits are ignored.
- R11: While `busy` is high every write request is denied. When a status request and an array request arrive in the same cycle, only the status write is considered and the array request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears all state |
| warm_rst | input | 1 | Synchronous reset of volatile state only |
| wp_pin | input | 1 | External write-protect pin level (0 = protect) |
| wel_set | input | 1 | Set write-enable latch strobe |
| wel_clr | input | 1 | Clear write-enable latch strobe |
| flag_set | input | 1 | Set flag strobe |
| flag_clr | input | 1 | Clear flag strobe |
| stat_wr_req | input | 1 | Status write request |
| stat_wr_data | input | 8 | Status write data byte |
| arr_wr_req | input | 1 | Array write request |
| arr_wr_addr | input | ADDR_W | Array write start address |
| q_addr | input | ADDR_W | Query address |
| q_locked | output | 1 | Query address lies in the locked block |
| q_arr_ok | output | 1 | An array write to the query address would be accepted now |
| q_stat_ok | output | 1 | A status write would be accepted now |
| wr_accept | output | 1 | Request in this cycle accepted |
| wr_deny | output | 1 | Request in this cycle denied |
| busy | output | 1 | Nonvolatile write in progress |
| wr_done | output | 1 | One-cycle pulse after a write completes |
| status_q | output | 8 | Status byte |

## Verification
The hardest situation to reach is a pin-level lock that appears in the middle of a status write that was accepted while the pin was high. The bench first commits lock-enable with the pin high, then starts a second status write. Two cycles into the busy window it drops `wp_pin`, and it waits for the commit before it tries a third write that must be refused. The other hard cases are a warm reset during a busy window, which must cancel the commit, and a status request and an array request arriving in the same cycle. Both are reached with directed tasks that place the strobes in the exact cycle.

// File: rtl/nwg_pkg.sv
package nwg_pkg;
   // status byte bit positions (the layout is visible to software)
   localparam int unsigned ST_WPEN = 7;
   localparam int unsigned ST_FLAG = 6;
   localparam int unsigned ST_BL1  = 3;
   localparam int unsigned ST_BL0  = 2;
   localparam int unsigned ST_WEL  = 1;
   localparam int unsigned ST_BUSY = 0;

   typedef struct packed {
      logic       lock_en;
      logic [1:0] blk;
   } nv_cfg_t;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_ARRAY  = 2'd1,
      OP_STATUS = 2'd2
   } nv_op_t;

   function automatic logic [7:0] pack_status(nv_cfg_t cfg, logic flag,
                                              logic wel, logic bsy);
      logic [7:0] s;
      s          = 8'h30;
      s[ST_WPEN] = cfg.lock_en;
      s[ST_FLAG] = flag;
      s[ST_BL1]  = cfg.blk[1];
      s[ST_BL0]  = cfg.blk[0];
      s[ST_WEL]  = wel;
      s[ST_BUSY] = bsy;
      return s;
   endfunction
endpackage

// File: rtl/nwg_lock_decode.sv
module nwg_lock_decode #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [1:0]        blk,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   localparam int unsigned TOP = ADDR_W - 1;

   logic [1:0] quarter;
   assign quarter = addr[TOP -: 2];

   always_comb begin
      unique case (blk)
         2'b00:   locked = 1'b0;
         2'b01:   locked = (quarter == 2'b11);
         2'b10:   locked = quarter[1];
         default: locked = 1'b1;
      endcase
   end
endmodule

// File: rtl/nwg_permit.sv
module nwg_permit (
   input  logic wel,
   input  logic busy,
   input  logic lock_en,
   input  logic wp_pin,
   input  logic arr_locked,
   input  logic qry_locked,
   output logic arr_ok,
   output logic qry_ok,
   output logic stat_ok
);
   logic free;
   logic hw_lock;

   assign free    = wel & ~busy;
   assign hw_lock = lock_en & ~wp_pin;
   assign arr_ok  = free & ~arr_locked;
   assign qry_ok  = free & ~qry_locked;
   assign stat_ok = free & ~hw_lock;
endmodule

// File: rtl/nwg_cycle_timer.sv
module nwg_cycle_timer #(
   parameter int unsigned WR_CYCLES = 500
) (
   input  logic clk,
   input  logic por_n,
   input  logic abort,
   input  logic start,
   output logic busy,
   output logic finish,
   output logic done
);
   localparam int unsigned CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;

   logic last;

   generate
      if (WR_CYCLES == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               cnt <= '0;
            end else if (start) begin
               cnt <= CNT_W'(WR_CYCLES - 1);
            end else if (busy && cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign last = (cnt == '0);
      end
   endgenerate

   assign finish = busy & last & ~abort;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else if (abort) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= finish;
         if (start)       busy <= 1'b1;
         else if (finish) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/nwg_state.sv
module nwg_state
   import nwg_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       warm_rst,
   input  logic       wel_set,
   input  logic       wel_clr,
   input  logic       flag_set,
   input  logic       flag_clr,
   input  logic       start_stat,
   input  logic       start_arr,
   input  logic [7:0] stat_data,
   input  logic       finish,
   output logic       wel,
   output logic       flag,
   output nv_cfg_t    cfg
);
   nv_cfg_t pend;
   nv_op_t  op;

   // volatile write-enable latch
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                       wel <= 1'b0;
      else if (warm_rst || finish)      wel <= 1'b0;
      else if (wel_clr)                 wel <= 1'b0;
      else if (wel_set)                 wel <= 1'b1;
   end

   // volatile user flag
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                       flag <= 1'b0;
      else if (warm_rst || flag_clr)    flag <= 1'b0;
      else if (flag_set)                flag <= 1'b1;
   end

   // pending operation captured at acceptance
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         op   <= OP_IDLE;
         pend <= '0;
      end else if (warm_rst || finish) begin
         op <= OP_IDLE;
      end else if (start_stat) begin
         op           <= OP_STATUS;
         pend.lock_en <= stat_data[ST_WPEN];
         pend.blk     <= {stat_data[ST_BL1], stat_data[ST_BL0]};
      end else if (start_arr) begin
         op <= OP_ARRAY;
      end
   end

   // nonvolatile settings: only a power-on reset clears them
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                              cfg <= '0;
      else if (finish && op == OP_STATUS)      cfg <= pend;
   end
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
   import nwg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned WR_CYCLES = 500
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst,
   input  logic              wp_pin,
   input  logic              wel_set,
   input  logic              wel_clr,
   input  logic              flag_set,
   input  logic              flag_clr,
   input  logic              stat_wr_req,
   input  logic [7:0]        stat_wr_data,
   input  logic              arr_wr_req,
   input  logic [ADDR_W-1:0] arr_wr_addr,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_locked,
   output logic              q_arr_ok,
   output logic              q_stat_ok,
   output logic              wr_accept,
   output logic              wr_deny,
   output logic              busy,
   output logic              wr_done,
   output logic [7:0]        status_q
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("nvm_write_guard: ADDR_W must be at least 2");
      end
      if (WR_CYCLES < 1) begin : g_bad_cyc
         $error("nvm_write_guard: WR_CYCLES must be at least 1");
      end
   endgenerate

   logic    wel, flag, finish;
   nv_cfg_t cfg;
   logic    arr_locked, arr_ok, stat_ok;
   logic    start_stat, start_arr;

   nwg_lock_decode #(.ADDR_W(ADDR_W)) u_dec_wr (
      .blk(cfg.blk), .addr(arr_wr_addr), .locked(arr_locked));

   nwg_lock_decode #(.ADDR_W(ADDR_W)) u_dec_q (
      .blk(cfg.blk), .addr(q_addr), .locked(q_locked));

   nwg_permit u_permit (
      .wel(wel), .busy(busy), .lock_en(cfg.lock_en), .wp_pin(wp_pin),
      .arr_locked(arr_locked), .qry_locked(q_locked),
      .arr_ok(arr_ok), .qry_ok(q_arr_ok), .stat_ok(stat_ok));

   // a status request shadows an array request in the same cycle
   assign start_stat = stat_wr_req & stat_ok & ~warm_rst;
   assign start_arr  = ~stat_wr_req & arr_wr_req & arr_ok & ~warm_rst;
   assign wr_accept  = start_stat | start_arr;
   assign wr_deny    = (stat_wr_req | arr_wr_req) & ~wr_accept;
   assign q_stat_ok  = stat_ok;

   nwg_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk(clk), .por_n(por_n), .abort(warm_rst), .start(wr_accept),
      .busy(busy), .finish(finish), .done(wr_done));

   nwg_state u_state (
      .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
      .wel_set(wel_set), .wel_clr(wel_clr),
      .flag_set(flag_set), .flag_clr(flag_clr),
      .start_stat(start_stat), .start_arr(start_arr),
      .stat_data(stat_wr_data), .finish(finish),
      .wel(wel), .flag(flag), .cfg(cfg));

   assign status_q = pack_status(cfg, flag, wel, busy);
endmodule

// File: rtl/nwg_chk.sv
module nwg_chk (
   input logic       clk,
   input logic       por_n,
   input logic       warm_rst,
   input logic       wp_pin,
   input logic       wel_set,
   input logic       wel_clr,
   input logic       stat_wr_req,
   input logic       wr_accept,
   input logic       busy,
   input logic       wr_done,
   input logic [7:0] status_q
);
   // R3
   accept_needs_wel_chk: assert property (@(posedge clk) disable iff (!por_n)
      wr_accept |-> status_q[1]);

   // R6
   accept_starts_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_accept && !warm_rst) |=> busy);

   // R6
   done_drops_wel_chk: assert property (@(posedge clk) disable iff (!por_n)
      wr_done |-> (!status_q[1] && !busy));

   // R1
   fixed_ones_chk: assert property (@(posedge clk) disable iff (!por_n)
      status_q[5:4] == 2'b11);

   // R4
   status_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
      (stat_wr_req && status_q[7] && !wp_pin) |-> !wr_accept);

   // R11
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!por_n)
      busy |-> !wr_accept);

   // R8
   wel_clear_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wel_set && wel_clr) |=> !status_q[1]);

   // R9
   warm_kills_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      warm_rst |=> (!busy && !wr_done && !status_q[1] && !status_q[6]));
endmodule

bind nvm_write_guard nwg_chk u_chk (
   .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wp_pin(wp_pin),
   .wel_set(wel_set), .wel_clr(wel_clr), .stat_wr_req(stat_wr_req),
   .wr_accept(wr_accept), .busy(busy), .wr_done(wr_done),
   .status_q(status_q));

// File: tb/nvm_write_guard_test.sv
`timescale 1ns/1ps
module nvm_write_guard_test;
   localparam int unsigned AW = 12;
   localparam int unsigned WC = 8;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          warm_rst = 1'b0;
   logic          wp_pin = 1'b1;
   logic          wel_set = 1'b0, wel_clr = 1'b0;
   logic          flag_set = 1'b0, flag_clr = 1'b0;
   logic          stat_wr_req = 1'b0;
   logic [7:0]    stat_wr_data = 8'h00;
   logic          arr_wr_req = 1'b0;
   logic [AW-1:0] arr_wr_addr = '0;
   logic [AW-1:0] q_addr = '0;
   logic          q_locked, q_arr_ok, q_stat_ok;
   logic          wr_accept, wr_deny, busy, wr_done;
   logic [7:0]    status_q;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   nvm_write_guard #(.ADDR_W(AW), .WR_CYCLES(WC)) uut (
      .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wp_pin(wp_pin),
      .wel_set(wel_set), .wel_clr(wel_clr),
      .flag_set(flag_set), .flag_clr(flag_clr),
      .stat_wr_req(stat_wr_req), .stat_wr_data(stat_wr_data),
      .arr_wr_req(arr_wr_req), .arr_wr_addr(arr_wr_addr),
      .q_addr(q_addr), .q_locked(q_locked), .q_arr_ok(q_arr_ok),
      .q_stat_ok(q_stat_ok), .wr_accept(wr_accept), .wr_deny(wr_deny),
      .busy(busy), .wr_done(wr_done), .status_q(status_q));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic exp_locked(input logic [1:0] bl, input logic [AW-1:0] a);
      case (bl)
         2'b00:   return 1'b0;
         2'b01:   return (a >= 12'hC00);
         2'b10:   return (a >= 12'h800);
         default: return 1'b1;
      endcase
   endfunction

   task automatic wel_on();
      wel_set = 1'b1; step(); wel_set = 1'b0;
   endtask

   task automatic stat_wr(input logic [7:0] d, input logic exp, input string req);
      stat_wr_req = 1'b1; stat_wr_data = d;
      #1 check(req, "status write accept", wr_accept, exp);
      step();
      stat_wr_req = 1'b0;
   endtask

   task automatic arr_wr(input logic [AW-1:0] a, input logic exp, input string req);
      arr_wr_req = 1'b1; arr_wr_addr = a;
      #1 check(req, "array write accept", wr_accept, exp);
      step();
      arr_wr_req = 1'b0;
   endtask

   // called at the negedge after the acceptance edge, minus `used` steps already spent
   task automatic wait_done(input int used);
      for (int i = 0; i < WC - used; i++) begin
         check("R6", "busy during write", busy, 1'b1);
         step();
      end
      check("R6", "done pulse", wr_done, 1'b1);
      check("R6", "busy low after write", busy, 1'b0);
      check("R6", "latch cleared after write", status_q[1], 1'b0);
   endtask

   task automatic set_cfg(input logic [7:0] d);
      wel_on();
      stat_wr(d, 1'b1, "R5");
      wait_done(0);
   endtask

   task automatic t_reset();
      check("R1", "reset status", status_q, 8'h30);
      check("R9", "reset busy", busy, 1'b0);
   endtask

   task automatic t_no_wel();
      #1 check("R3", "q_stat_ok without latch", q_stat_ok, 1'b0);
      q_addr = 12'h000;
      #1 check("R3", "q_arr_ok without latch", q_arr_ok, 1'b0);
      stat_wr(8'h0C, 1'b0, "R3");
      arr_wr(12'h000, 1'b0, "R3");
      check("R3", "status unchanged", status_q, 8'h30);
   endtask

   task automatic t_ignored_bits();
      wel_on();
      check("R1", "latch bit", status_q, 8'h32);
      stat_wr(8'b0111_0011, 1'b1, "R10");
      check("R1", "busy bit", status_q, 8'h33);
      wait_done(0);
      check("R10", "other bits ignored", status_q, 8'h30);
   endtask

   task automatic t_ranges();
      logic [AW-1:0] probes [6];
      probes = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
      for (int b = 1; b < 5; b++) begin
         logic [1:0] bl;
         bl = 2'(b);
         set_cfg({4'b0000, bl, 2'b00});
         check("R2", "block bits", status_q[3:2], bl);
         for (int p = 0; p < 6; p++) begin
            q_addr = probes[p];
            #1 check("R2", $sformatf("locked bl=%0d a=%h", bl, probes[p]),
                     q_locked, exp_locked(bl, probes[p]));
         end
         if (bl == 2'b01) begin
            wel_on();
            arr_wr(12'hC00, 1'b0, "R2");
            arr_wr(12'hBFF, 1'b1, "R2");
            wait_done(0);
         end
      end
   endtask

   task automatic t_lock();
      set_cfg(8'h84);
      check("R10", "lock-enable stored", status_q, 8'hB4);
      wp_pin = 1'b0;
      wel_on();
      #1 check("R4", "q_stat_ok locked", q_stat_ok, 1'b0);
      stat_wr(8'h80, 1'b0, "R4");
      arr_wr(12'h100, 1'b1, "R4");
      wait_done(0);
      wel_on();
      wp_pin = 1'b1;
      #1 check("R5", "q_stat_ok pin high", q_stat_ok, 1'b1);
      stat_wr(8'h88, 1'b1, "R7");
      step(); step();
      wp_pin = 1'b0;
      wait_done(2);
      check("R7", "commit despite pin drop", status_q, 8'hB8);
      wel_on();
      stat_wr(8'h00, 1'b0, "R7");
      wp_pin = 1'b1;
      set_cfg(8'h00);
      wp_pin = 1'b0;
      wel_on();
      #1 check("R5", "q_stat_ok lock-enable off", q_stat_ok, 1'b1);
      wel_clr = 1'b1; step(); wel_clr = 1'b0;
      wp_pin = 1'b1;
   endtask

   task automatic t_busy();
      wel_on();
      arr_wr(12'h010, 1'b1, "R11");
      arr_wr(12'h020, 1'b0, "R11");
      stat_wr(8'h00, 1'b0, "R11");
      wait_done(2);
      wel_on();
      stat_wr_req = 1'b1; stat_wr_data = 8'h04;
      arr_wr_req = 1'b1;  arr_wr_addr = 12'h000;
      #1 check("R11", "joint request accepted", wr_accept, 1'b1);
      step();
      stat_wr_req = 1'b0; arr_wr_req = 1'b0;
      wait_done(0);
      check("R11", "status write won", status_q, 8'h34);
   endtask

   task automatic t_flag();
      flag_set = 1'b1; step(); flag_set = 1'b0;
      check("R8", "flag set", status_q[6], 1'b1);
      flag_set = 1'b1; flag_clr = 1'b1; step(); flag_set = 1'b0; flag_clr = 1'b0;
      check("R8", "flag clear wins", status_q[6], 1'b0);
      wel_set = 1'b1; wel_clr = 1'b1; step(); wel_set = 1'b0; wel_clr = 1'b0;
      check("R8", "latch clear wins", status_q[1], 1'b0);
   endtask

   task automatic t_resets();
      flag_set = 1'b1; step(); flag_set = 1'b0;
      wel_on();
      check("R9", "before warm reset", status_q, 8'h76);
      warm_rst = 1'b1; step(); warm_rst = 1'b0;
      check("R9", "after warm reset", status_q, 8'h34);
      wel_on();
      stat_wr(8'h8C, 1'b1, "R9");
      step();
      warm_rst = 1'b1; step(); warm_rst = 1'b0;
      for (int i = 0; i < WC; i++) begin
         check("R9", "no done after abort", wr_done, 1'b0);
         step();
      end
      check("R9", "aborted write not committed", status_q, 8'h34);
      por_n = 1'b0; step(); por_n = 1'b1; step();
      check("R9", "power-on clears all", status_q, 8'h30);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step(); step();
      por_n = 1'b1;
      step();
      t_reset();
      t_no_wel();
      t_ignored_bits();
      t_ranges();
      t_lock();
      t_busy();
      t_flag();
      t_resets();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule